// File: doc/BRIEF.md
# EEPROM Page Write Buffer Controller

This block accepts byte writes from a parallel microcontroller bus. It gathers them in a 64-byte volatile page buffer and does not commit any of them at once. The first accepted write opens a gathering window and fixes the target page from the upper address bits. Each further write to the same page refills the buffer and restarts an inactivity timer. When the timer runs out, an internal store begins. The store lasts a fixed number of cycles and then writes only the buffered bytes into a modelled nonvolatile array. The old contents of those bytes are replaced without a separate erase step.

Software follows progress in two ways. The ready output is low from the first accepted write until the store has finished. While the block is busy, reads return two status bits: a polling bit that is the inverse of bit 7 of the last byte written, and a toggle bit that flips on every read. Once the block is idle, reads return array contents. A write that names a different page inside an open window is dropped and sets a sticky error flag. Writes that arrive during a store are ignored. A single byte write follows the same path: it is a window that holds one byte.

Top module: `eepw_ctrl`

## Requirements
- R1: A write is accepted only in a cycle where `cs` and `we` are both 1. A cycle with only one of them high changes nothing: `ready` stays 1 and the array keeps its contents.
- R2: The store starts TIMEOUT_CYC cycles after the last accepted write of a window. A write accepted in the very cycle the window would close is merged and restarts the window. From the last accepted write, `ready` returns to 1 after exactly TIMEOUT_CYC + STORE_CYC cycles.
- R3: The buffer holds 64 bytes selected by `addr[5:0]`. Bytes may be written in any order, and a later write to the same offset replaces the earlier one.
- R4: The page, `addr[14:6]`, is latched on the first write of a window. A later write in that window with a different page is dropped and sets `page_err`. `page_err` stays at 1 until `err_clr` is 1 at a clock edge; if a new mismatch arrives in that same cycle, the set wins.
- R5: When the store ends, only the buffered bytes of the page change in the array, and each takes the buffered value whatever its old value was (for example, 0x00 to 0xFF). The other bytes of the page keep their old values.
- R6: `ready` drops to 0 in the cycle after the first accepted write of a window and stays at 0 through the gathering and store phases.
- R7: A read is a cycle with `cs`=1, `rd`=1 and `we`=0; `rdata` shows the result from the next cycle on and holds it until the next read. While busy, a read returns bit 7 = inverted bit 7 of the last accepted byte, bit 6 = the toggle bit, and bits 5..0 = 0. The toggle bit is 0 on the first busy read of each window and inverts after every busy read.
- R8: While idle, a read returns the array byte at the address. After reset every array byte reads 0xFF. The array models MODEL_PAGES pages, and the page field is taken modulo that count.
- R9: Writes accepted while a store is in progress are ignored. They do not enter the buffer, do not change the store length and do not change the array.
- R10: A lone write produces a store of that one byte, with the same timing as a full page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Array select |
| we | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| err_clr | input | 1 | Clears the sticky page error flag |
| addr | input | 15 | Byte address: page in bits 14..6, offset in bits 5..0 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or busy status |
| ready | output | 1 | 1 when idle, 0 while gathering or storing |
| page_err | output | 1 | Sticky flag for a dropped write to another page |

## Verification
Two functions can fall in the same clock edge. The inactivity timer may close the window in the same cycle that a new write to the page arrives. The bench places the second write exactly TIMEOUT_CYC cycles after the first. It judges the result in two ways: `ready` must come back only TIMEOUT_CYC + STORE_CYC cycles after the second write, and both bytes must read back from the array. A mismatched page write and an `err_clr` in the same cycle is the second collision, and the flag must end up set.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_STORE  = 2'd2
    } eepw_state_e;

endpackage

// File: rtl/eepw_cycle_timer.sv
module eepw_cycle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load) begin
            count_d = load_val;
        end else if (count_q != '0) begin
            count_d = count_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign zero = (count_q == '0);

endmodule

// File: rtl/eepw_page_buf.sv
module eepw_page_buf #(
    parameter int OFF_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [OFF_W-1:0]             wr_off,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         clr,
    output logic [(1<<OFF_W)-1:0][DATA_W-1:0] bytes,
    output logic [(1<<OFF_W)-1:0]        mask
);

    localparam int NBYTES = 1 << OFF_W;

    logic [NBYTES-1:0][DATA_W-1:0] bytes_d, bytes_q;
    logic [NBYTES-1:0]             mask_d, mask_q;

    always_comb begin
        bytes_d = bytes_q;
        mask_d  = mask_q;
        if (clr) begin
            mask_d = '0;
        end else if (wr_en) begin
            bytes_d[wr_off] = wr_data;
            mask_d[wr_off]  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bytes_q <= '0;
            mask_q  <= '0;
        end else begin
            bytes_q <= bytes_d;
            mask_q  <= mask_d;
        end
    end

    assign bytes = bytes_q;
    assign mask  = mask_q;

endmodule

// File: rtl/eepw_array.sv
module eepw_array #(
    parameter int MODEL_PAGES = 16,
    parameter int OFF_W       = 6,
    parameter int DATA_W      = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              commit,
    input  logic [$clog2(MODEL_PAGES)-1:0]    commit_page,
    input  logic [(1<<OFF_W)-1:0][DATA_W-1:0] commit_bytes,
    input  logic [(1<<OFF_W)-1:0]             commit_mask,
    input  logic [$clog2(MODEL_PAGES)-1:0]    rd_page,
    input  logic [OFF_W-1:0]                  rd_off,
    output logic [DATA_W-1:0]                 rd_data
);

    localparam int NBYTES = 1 << OFF_W;
    localparam int MP_W   = $clog2(MODEL_PAGES);
    localparam int DEPTH  = MODEL_PAGES * NBYTES;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Erase is implicit: a committed byte simply replaces the old cell value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (commit) begin
            for (int j = 0; j < NBYTES; j++) begin
                if (commit_mask[j]) mem_q[{commit_page, OFF_W'(j)}] <= commit_bytes[j];
            end
        end
    end

    logic [MP_W+OFF_W-1:0] rd_idx;
    assign rd_idx  = {rd_page, rd_off};
    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/eepw_ctrl.sv
module eepw_ctrl
    import eepw_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int OFF_W       = 6,
    parameter int DATA_W      = 8,
    parameter int TIMEOUT_CYC = 15000,
    parameter int STORE_CYC   = 375000,
    parameter int MODEL_PAGES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic              rd,
    input  logic              err_clr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              page_err
);

    localparam int NBYTES = 1 << OFF_W;
    localparam int PG_W   = ADDR_W - OFF_W;
    localparam int MP_W   = $clog2(MODEL_PAGES);
    localparam int MAXC   = (TIMEOUT_CYC > STORE_CYC) ? TIMEOUT_CYC : STORE_CYC;
    localparam int CNT_W  = $clog2(MAXC + 1);

    typedef struct packed {
        eepw_state_e       state;
        logic [PG_W-1:0]   page;
        logic              last7;
        logic              tog;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                          wr_acc, rd_acc, page_match;
    logic                          buf_wr, buf_clr, commit;
    logic                          tmr_load, tmr_zero;
    logic [CNT_W-1:0]              tmr_val;
    logic [PG_W-1:0]               page_in;
    logic [OFF_W-1:0]              off_in;
    logic [NBYTES-1:0][DATA_W-1:0] buf_bytes;
    logic [NBYTES-1:0]             buf_mask;
    logic [DATA_W-1:0]             arr_rd;
    logic [MP_W-1:0]               rd_page_m, commit_page_m;

    assign wr_acc     = cs & we;
    assign rd_acc     = cs & rd & ~we;
    assign page_in    = addr[ADDR_W-1:OFF_W];
    assign off_in     = addr[OFF_W-1:0];
    assign page_match = (page_in == ctl_q.page);
    assign rd_page_m     = page_in[MP_W-1:0];
    assign commit_page_m = ctl_q.page[MP_W-1:0];

    always_comb begin
        ctl_d    = ctl_q;
        buf_wr   = 1'b0;
        buf_clr  = 1'b0;
        commit   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = CNT_W'(TIMEOUT_CYC - 1);

        if (err_clr) ctl_d.err = 1'b0;

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (wr_acc) begin
                    ctl_d.state = ST_GATHER;
                    ctl_d.page  = page_in;
                    ctl_d.last7 = wdata[DATA_W-1];
                    ctl_d.tog   = 1'b0;
                    buf_wr      = 1'b1;
                    tmr_load    = 1'b1;
                end
            end
            ST_GATHER: begin
                if (wr_acc && page_match) begin
                    // A matching write restarts the window, even in the closing cycle.
                    ctl_d.last7 = wdata[DATA_W-1];
                    buf_wr      = 1'b1;
                    tmr_load    = 1'b1;
                end else if (tmr_zero) begin
                    ctl_d.state = ST_STORE;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(STORE_CYC - 1);
                end
                if (wr_acc && !page_match) ctl_d.err = 1'b1;
            end
            ST_STORE: begin
                if (tmr_zero) begin
                    ctl_d.state = ST_IDLE;
                    commit      = 1'b1;
                    buf_clr     = 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase

        if (rd_acc) begin
            if (ctl_q.state != ST_IDLE) begin
                ctl_d.rdata = '0;
                ctl_d.rdata[DATA_W-1] = ~ctl_q.last7;
                ctl_d.rdata[DATA_W-2] = ctl_q.tog;
                ctl_d.tog             = ~ctl_q.tog;
            end else begin
                ctl_d.rdata = arr_rd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    eepw_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    eepw_page_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_wr),
        .wr_off  (off_in),
        .wr_data (wdata),
        .clr     (buf_clr),
        .bytes   (buf_bytes),
        .mask    (buf_mask)
    );

    eepw_array #(.MODEL_PAGES(MODEL_PAGES), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit       (commit),
        .commit_page  (commit_page_m),
        .commit_bytes (buf_bytes),
        .commit_mask  (buf_mask),
        .rd_page      (rd_page_m),
        .rd_off       (off_in),
        .rd_data      (arr_rd)
    );

    assign rdata    = ctl_q.rdata;
    assign ready    = (ctl_q.state == ST_IDLE);
    assign page_err = ctl_q.err;

    // R2: a store is only ever entered from an open gathering window
    a_r2_store_from_gather: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_STORE && $past(ctl_q.state) != ST_STORE)
            |-> $past(ctl_q.state) == ST_GATHER);

    // R4: the latched page never moves inside a window
    a_r4_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_GATHER && $past(ctl_q.state) == ST_GATHER)
            |-> $stable(ctl_q.page));

    // R4: the error flag only falls on a clear request
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.err && !err_clr) |=> ctl_q.err);

    // R9: buffer contents frozen while storing
    a_r9_store_freezes_buf: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_STORE) |=> (ctl_q.state == ST_IDLE) || $stable(buf_mask));

    // R5: nothing left marked in the buffer once idle
    a_r5_mask_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_IDLE) |-> (buf_mask == '0));

    // R6: ready cannot return while the buffer still holds bytes
    a_r6_ready_buf_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_mask != '0) |-> !ready);

endmodule

// File: tb/eepw_ctrl_bench.sv
module eepw_ctrl_bench;

    localparam int T = 20;
    localparam int S = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, we = 1'b0, rd = 1'b0, err_clr = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        ready, page_err;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    eepw_ctrl #(.TIMEOUT_CYC(T), .STORE_CYC(S)) u_eepw_ctrl (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .rd(rd), .err_clr(err_clr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready), .page_err(page_err)
    );

    // {addr, write data, expected final array value}
    localparam int NV = 6;
    localparam logic [30:0] VEC [NV] = '{
        {15'h0C5, 8'h11, 8'h22},
        {15'h0C0, 8'hA5, 8'hA5},
        {15'h0FF, 8'h3C, 8'h3C},
        {15'h0C5, 8'h22, 8'h22},
        {15'h0C9, 8'h00, 8'h00},
        {15'h0C1, 8'h80, 8'h80}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic rdb(input logic [14:0] a, output logic [7:0] d);
        cs = 1'b1; rd = 1'b1; addr = a;
        @(posedge clk); @(negedge clk);
        cs = 1'b0; rd = 1'b0;
        d = rdata;
    endtask

    task automatic wait_ready(output int cnt);
        cnt = 0;
        while (!ready && cnt < 10000) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    initial begin
        #1_000_000;
        n_err++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R8)
        check("R6 ready after reset", ready, 1);
        check("R4 page_err after reset", page_err, 0);
        rdb(15'h000, d);
        check("R8 erased after reset", d, 8'hFF);

        // R1: half strobes do nothing
        cs = 1'b1; we = 1'b0; addr = 15'h002; wdata = 8'h12;
        @(negedge clk);
        cs = 1'b0; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        repeat (T + S + 2) @(negedge clk);
        check("R1 ready unchanged", ready, 1);
        rdb(15'h002, d);
        check("R1 array unchanged", d, 8'hFF);

        // Table of page writes (R3, R5, R6, R7)
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][30:16], VEC[i][15:8]);
            if (i == 0) check("R6 ready low after first write", ready, 0);
        end
        rdb(15'h000, d);
        check("R7 busy status first read", d, 8'h00);
        rdb(15'h000, d);
        check("R7 busy status toggled", d, 8'h40);
        wait_ready(cnt);
        for (int i = 0; i < NV; i++) begin
            rdb(VEC[i][30:16], d);
            check("R3 page byte readback", d, VEC[i][7:0]);
        end
        rdb(15'h0C2, d);
        check("R5 unwritten byte kept", d, 8'hFF);

        // R10 / R2: lone write with exact timing
        wr(15'h0C9, 8'h7E);
        rdb(15'h0C9, d);
        check("R7 status polling bit7 inverted", d, 8'h80);
        wait_ready(cnt);
        check("R2 R10 ready delay", cnt, T + S - 1);
        rdb(15'h0C9, d);
        check("R5 R10 overwrite no erase", d, 8'h7E);
        rdb(15'h0C0, d);
        check("R5 neighbour kept", d, 8'hA5);

        // R2: write lands in the closing cycle
        wr(15'h200, 8'h31);
        repeat (T - 1) @(negedge clk);
        wr(15'h201, 8'h32);
        wait_ready(cnt);
        check("R2 coincident write restarts window", cnt, T + S);
        rdb(15'h200, d);
        check("R2 first byte stored", d, 8'h31);
        rdb(15'h201, d);
        check("R2 coincident byte stored", d, 8'h32);

        // R9: write during store ignored
        wr(15'h240, 8'h44);
        repeat (T + 2) @(negedge clk);
        wr(15'h241, 8'h55);
        wait_ready(cnt);
        check("R9 store length unchanged", cnt, T + S - T - 3);
        rdb(15'h241, d);
        check("R9 ignored byte", d, 8'hFF);
        rdb(15'h240, d);
        check("R9 window byte stored", d, 8'h44);

        // R4: page mismatch dropped, sticky, set beats clear
        wr(15'h100, 8'h5A);
        wr(15'h141, 8'h66);
        check("R4 page_err set", page_err, 1);
        cs = 1'b1; we = 1'b1; addr = 15'h182; wdata = 8'h77; err_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        cs = 1'b0; we = 1'b0; err_clr = 1'b0;
        check("R4 set wins over clear", page_err, 1);
        wait_ready(cnt);
        rdb(15'h141, d);
        check("R4 dropped byte", d, 8'hFF);
        rdb(15'h182, d);
        check("R4 dropped byte 2", d, 8'hFF);
        rdb(15'h100, d);
        check("R4 window byte stored", d, 8'h5A);
        check("R4 flag sticky after store", page_err, 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check("R4 flag cleared", page_err, 0);

        // R8: page field modulo model size (page 19 aliases page 3)
        rdb(15'h4C0, d);
        check("R8 page alias", d, 8'hA5);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule